// File: doc/BRIEF.md
# Cipher Engine Register Block

This block is the software-facing register file of a DMA-driven AES-128 CBC engine. A 32-bit word bus reaches five registers. One is a control and status word. Two hold the source and destination buffer addresses. The other two are single-address load ports, where four successive word writes build the 128-bit key or the 128-bit initial vector. The block never touches data. It hands a frozen set of command fields to the datapath sequencer, fires a one-cycle launch strobe, and then waits for the sequencer to report completion and, optionally, an error.

Software loads the addresses, the key and the IV. It then writes the control word with the launch bit set. While a command runs, the control register reads back busy, and all writes are dropped except a write of zero. A write of zero rewinds both load-port pointers and clears the status flags. At completion, the block can raise an interrupt that stays asserted until software next writes the control word. The registers are word-wide and big-endian, with bit 31 the most significant. The bus accepts every request at once. Read data comes back combinationally in the same cycle.

Top module: `aes_ctrl_regs`

## Requirements
- R1: Word offsets are 0x00 control, 0x04 source address, 0x08 destination address, 0x0C key port and 0x10 IV port. The source and destination registers store the written value with bits 3:0 forced to zero. They read back that value and drive it on `srcAddr` and `dstAddr`.
- R2: The first write to a load port lands in bits 127:96 of its vector, the second in 95:64, the third in 63:32 and the fourth in 31:0. The key port fills `keyOut` and the IV port fills `ivOut`.
- R3: Each load port's word pointer wraps to the most significant word after the fourth write. A write of 0 to the control register rewinds both pointers to the most significant word.
- R4: A control write with bit 31 set while idle makes `startPulse` high for exactly the following cycle. From that cycle, `busy` and control read bit 31 stay 1 until `seqDone` is sampled high.
- R5: An accepted control write latches bit 30 (interrupt enable), bit 28 (cipher enable, 0 means plain copy), bit 27 (0 encrypt, 1 decrypt), bit 12 (use newly loaded IV) and bits 11:0 (block count minus one). Each field reads back at the same position and drives its own output.
- R6: When `seqDone` is sampled while busy with `seqError` high, control bit 29 becomes 1. It stays 1 through nonzero control writes until a control write of 0.
- R7: When `seqDone` is sampled while busy with interrupt enable set, `irq` rises and holds until the next control write. With interrupt enable clear, `irq` stays low.
- R8: While busy, writes to the source, destination, key and IV registers and nonzero control writes have no effect. A control write of 0 still rewinds the pointers and clears the flags, but it keeps busy and the latched fields.
- R9: Control bits 26:13 read as 0. The key port, the IV port and unmapped offsets read as 0.
- R10: `seqDone` sampled while idle changes neither status nor `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Bus request present |
| busWrite | input | 1 | 1 write, 0 read |
| busAddr | input | 5 | Byte offset of the word register |
| busWdata | input | 32 | Write data |
| busReady | output | 1 | Request accepted (always 1) |
| busRdata | output | 32 | Read data, same cycle |
| startPulse | output | 1 | One-cycle command launch |
| busy | output | 1 | Command in flight |
| cipherEn | output | 1 | 1 cipher, 0 plain copy |
| decrypt | output | 1 | 1 decrypt, 0 encrypt |
| useNewIv | output | 1 | Restart chaining from `ivOut` |
| blockCountM1 | output | 12 | Blocks to process minus one |
| srcAddr | output | 32 | Aligned source address |
| dstAddr | output | 32 | Aligned destination address |
| keyOut | output | 128 | Assembled key |
| ivOut | output | 128 | Assembled IV |
| seqDone | input | 1 | Sequencer completion strobe |
| seqError | input | 1 | Error qualifier for `seqDone` |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that `seqDone` is a single-cycle strobe and that `seqError` is meaningful only alongside it. They also assume that the bus presents at most one request per cycle, so that a load-port write and a pointer rewind never arrive together. The stimulus applies every request for exactly one cycle. It raises `seqDone` for one cycle only, and it never lines a completion up with a control write, so the ordering between interrupt set and interrupt clear is never stressed.

// File: rtl/aes_regs_pkg.sv
package aes_regs_pkg;
  localparam int unsigned REG_ADDR_W = 5;

  localparam logic [REG_ADDR_W-1:0] OFF_CTRL = 5'h00;
  localparam logic [REG_ADDR_W-1:0] OFF_SRC  = 5'h04;
  localparam logic [REG_ADDR_W-1:0] OFF_DST  = 5'h08;
  localparam logic [REG_ADDR_W-1:0] OFF_KEY  = 5'h0C;
  localparam logic [REG_ADDR_W-1:0] OFF_IV   = 5'h10;

  localparam int unsigned BIT_GO    = 31;
  localparam int unsigned BIT_IRQEN = 30;
  localparam int unsigned BIT_ERR   = 29;
  localparam int unsigned BIT_CIPH  = 28;
  localparam int unsigned BIT_DEC   = 27;
  localparam int unsigned BIT_NEWIV = 12;

  typedef struct packed {
    logic wrSrc;
    logic wrDst;
    logic wrKey;
    logic wrIv;
    logic clrPtr;
  } regStrobe_t;
endpackage

// File: rtl/aes_load_port.sv
module aes_load_port #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic                          clrPtr,
  input  logic [DATA_W-1:0]             wrData,
  output logic [NUM_WORDS*DATA_W-1:0]   vecOut
);
  localparam int unsigned PTR_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_WORDS - 1);

  logic [PTR_W-1:0] ptrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (clrPtr) begin
      ptrQ <= '0;
    end else if (wrEn) begin
      ptrQ <= (ptrQ == LAST) ? '0 : ptrQ + 1'b1;
    end
  end

  // first word written goes to the most significant slot
  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rstN) begin
        vecOut[(NUM_WORDS-w)*DATA_W-1 -: DATA_W] <= '0;
      end else if (wrEn && ptrQ == PTR_W'(w)) begin
        vecOut[(NUM_WORDS-w)*DATA_W-1 -: DATA_W] <= wrData;
      end
    end
  end

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !clrPtr && ptrQ == LAST) |=> (ptrQ == '0)); // R3
  AST_PTR_CLR: assert property (@(posedge clk) disable iff (!rstN)
    clrPtr |=> (ptrQ == '0)); // R3
endmodule

// File: rtl/aes_regs_dp.sv
module aes_regs_dp
  import aes_regs_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned ALIGN_BITS = 4,
  parameter int unsigned KEY_WORDS  = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  regStrobe_t                    strobe,
  input  logic [DATA_W-1:0]             wrData,
  output logic [DATA_W-1:0]             srcAddr,
  output logic [DATA_W-1:0]             dstAddr,
  output logic [KEY_WORDS*DATA_W-1:0]   keyOut,
  output logic [KEY_WORDS*DATA_W-1:0]   ivOut
);
  logic [DATA_W-1:0] alignedData;
  assign alignedData = {wrData[DATA_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr <= '0;
      dstAddr <= '0;
    end else begin
      if (strobe.wrSrc) srcAddr <= alignedData;
      if (strobe.wrDst) dstAddr <= alignedData;
    end
  end

  aes_load_port #(.DATA_W(DATA_W), .NUM_WORDS(KEY_WORDS)) i_keyPort (
    .clk(clk), .rstN(rstN), .wrEn(strobe.wrKey), .clrPtr(strobe.clrPtr),
    .wrData(wrData), .vecOut(keyOut));

  aes_load_port #(.DATA_W(DATA_W), .NUM_WORDS(KEY_WORDS)) i_ivPort (
    .clk(clk), .rstN(rstN), .wrEn(strobe.wrIv), .clrPtr(strobe.clrPtr),
    .wrData(wrData), .vecOut(ivOut));

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.wrSrc, strobe.wrDst, strobe.wrKey, strobe.wrIv, strobe.clrPtr}) <= 1); // R1
endmodule

// File: rtl/aes_regs_ctrl.sv
module aes_regs_ctrl
  import aes_regs_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned COUNT_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busValid,
  input  logic                  busWrite,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [DATA_W-1:0]     srcAddr,
  input  logic [DATA_W-1:0]     dstAddr,
  output regStrobe_t            strobe,
  output logic                  startPulse,
  output logic                  busy,
  output logic                  cipherEn,
  output logic                  decrypt,
  output logic                  useNewIv,
  output logic [COUNT_W-1:0]    blockCountM1,
  input  logic                  seqDone,
  input  logic                  seqError,
  output logic                  irq
);
  logic wrCycle, ctrlHit, zeroWrite, ctrlAccept, startReq, finish;
  logic startQ, busyQ, errQ, irqQ, irqEnQ, ciphQ, decQ, newIvQ;
  logic [COUNT_W-1:0] countQ;

  assign wrCycle    = busValid && busWrite;
  assign ctrlHit    = wrCycle && (busAddr == OFF_CTRL);
  assign zeroWrite  = ctrlHit && (busWdata == '0);
  assign ctrlAccept = ctrlHit && !busyQ;
  assign startReq   = ctrlAccept && busWdata[BIT_GO];
  assign finish     = busyQ && seqDone;

  always_comb begin
    strobe        = '0;
    strobe.wrSrc  = wrCycle && !busyQ && (busAddr == OFF_SRC);
    strobe.wrDst  = wrCycle && !busyQ && (busAddr == OFF_DST);
    strobe.wrKey  = wrCycle && !busyQ && (busAddr == OFF_KEY);
    strobe.wrIv   = wrCycle && !busyQ && (busAddr == OFF_IV);
    strobe.clrPtr = zeroWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= 1'b0;
      busyQ  <= 1'b0;
      errQ   <= 1'b0;
      irqQ   <= 1'b0;
      irqEnQ <= 1'b0;
      ciphQ  <= 1'b0;
      decQ   <= 1'b0;
      newIvQ <= 1'b0;
      countQ <= '0;
    end else begin
      startQ <= startReq;
      if (ctrlAccept) begin
        irqEnQ <= busWdata[BIT_IRQEN];
        ciphQ  <= busWdata[BIT_CIPH];
        decQ   <= busWdata[BIT_DEC];
        newIvQ <= busWdata[BIT_NEWIV];
        countQ <= busWdata[COUNT_W-1:0];
      end
      if (startReq)    busyQ <= 1'b1;
      else if (finish) busyQ <= 1'b0;
      if (finish && seqError) errQ <= 1'b1;
      else if (zeroWrite)     errQ <= 1'b0;
      if (finish && irqEnQ)                      irqQ <= 1'b1;
      else if (ctrlHit && (!busyQ || zeroWrite)) irqQ <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFF_CTRL: begin
        busRdata[BIT_GO]        = busyQ;
        busRdata[BIT_IRQEN]     = irqEnQ;
        busRdata[BIT_ERR]       = errQ;
        busRdata[BIT_CIPH]      = ciphQ;
        busRdata[BIT_DEC]       = decQ;
        busRdata[BIT_NEWIV]     = newIvQ;
        busRdata[COUNT_W-1:0]   = countQ;
      end
      OFF_SRC: busRdata = srcAddr;
      OFF_DST: busRdata = dstAddr;
      default: busRdata = '0;
    endcase
  end

  assign startPulse   = startQ;
  assign busy         = busyQ;
  assign irq          = irqQ;
  assign cipherEn     = ciphQ;
  assign decrypt      = decQ;
  assign useNewIv     = newIvQ;
  assign blockCountM1 = countQ;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    startQ |=> !startQ); // R4
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    startQ |-> busyQ); // R4
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && $past(busyQ)) |-> ($stable(countQ) && $stable(irqEnQ) && $stable(decQ) && $stable(ciphQ))); // R8
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> $past(finish && irqEnQ)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !zeroWrite) |=> errQ); // R6
  AST_IDLE_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (!busyQ && seqDone && !ctrlHit) |=> ($stable(errQ) && $stable(irqQ))); // R10
endmodule

// File: rtl/aes_ctrl_regs.sv
module aes_ctrl_regs
  import aes_regs_pkg::*;
#(
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned COUNT_W    = 12,
  parameter int unsigned ALIGN_BITS = 4,
  parameter int unsigned KEY_WORDS  = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        busValid,
  input  logic                        busWrite,
  input  logic [REG_ADDR_W-1:0]       busAddr,
  input  logic [DATA_W-1:0]           busWdata,
  output logic                        busReady,
  output logic [DATA_W-1:0]           busRdata,
  output logic                        startPulse,
  output logic                        busy,
  output logic                        cipherEn,
  output logic                        decrypt,
  output logic                        useNewIv,
  output logic [COUNT_W-1:0]          blockCountM1,
  output logic [DATA_W-1:0]           srcAddr,
  output logic [DATA_W-1:0]           dstAddr,
  output logic [KEY_WORDS*DATA_W-1:0] keyOut,
  output logic [KEY_WORDS*DATA_W-1:0] ivOut,
  input  logic                        seqDone,
  input  logic                        seqError,
  output logic                        irq
);
  regStrobe_t strobe;

  assign busReady = 1'b1;

  aes_regs_ctrl #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .strobe(strobe),
    .startPulse(startPulse), .busy(busy), .cipherEn(cipherEn),
    .decrypt(decrypt), .useNewIv(useNewIv), .blockCountM1(blockCountM1),
    .seqDone(seqDone), .seqError(seqError), .irq(irq));

  aes_regs_dp #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS), .KEY_WORDS(KEY_WORDS)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(busWdata),
    .srcAddr(srcAddr), .dstAddr(dstAddr), .keyOut(keyOut), .ivOut(ivOut));
endmodule

// File: tb/test_aes_ctrl_regs.sv
module test_aes_ctrl_regs;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rstN = 1'b0;
  logic busValid = 1'b0, busWrite = 1'b0;
  logic [4:0] busAddr = '0;
  logic [31:0] busWdata = '0;
  logic busReady;
  logic [31:0] busRdata, srcAddr, dstAddr;
  logic startPulse, busy, cipherEn, decrypt, useNewIv, irq;
  logic [11:0] blockCountM1;
  logic [127:0] keyOut, ivOut;
  logic seqDone = 1'b0, seqError = 1'b0;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  aes_ctrl_regs i_aes_ctrl_regs (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busReady(busReady),
    .busRdata(busRdata), .startPulse(startPulse), .busy(busy),
    .cipherEn(cipherEn), .decrypt(decrypt), .useNewIv(useNewIv),
    .blockCountM1(blockCountM1), .srcAddr(srcAddr), .dstAddr(dstAddr),
    .keyOut(keyOut), .ivOut(ivOut), .seqDone(seqDone), .seqError(seqError),
    .irq(irq));

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b0; busAddr = a;
    #1 d = busRdata;
    busValid = 1'b0;
  endtask

  task automatic done(input logic e);
    @(negedge clk);
    seqDone = 1'b1; seqError = e;
    @(negedge clk);
    seqDone = 1'b0; seqError = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(5'h00, v);
    check("R4 reset ctrl", v, 0);
    check("R7 reset irq", irq, 0);
    check("R2 reset key", keyOut, 0);
    check("R4 reset start", startPulse, 0);
  endtask

  task automatic t_addr();
    logic [31:0] v;
    wr(5'h04, 32'h1234567F);
    wr(5'h08, 32'hFFFFFFFF);
    rd(5'h04, v); check("R1 src readback", v, 32'h12345670);
    rd(5'h08, v); check("R1 dst readback", v, 32'hFFFFFFF0);
    check("R1 src port", srcAddr, 32'h12345670);
    check("R1 dst port", dstAddr, 32'hFFFFFFF0);
  endtask

  task automatic t_key();
    wr(5'h0C, 32'hA0A0A0A0); wr(5'h0C, 32'hB1B1B1B1);
    wr(5'h0C, 32'hC2C2C2C2); wr(5'h0C, 32'hD3D3D3D3);
    check("R2 key order", keyOut, {32'hA0A0A0A0, 32'hB1B1B1B1, 32'hC2C2C2C2, 32'hD3D3D3D3});
    wr(5'h10, 32'h11111111); wr(5'h10, 32'h22222222);
    wr(5'h10, 32'h33333333); wr(5'h10, 32'h44444444);
    check("R2 iv order", ivOut, {32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444});
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 5; i++) wr(5'h0C, 32'hE0000000 + i);
    check("R3 wrap", keyOut, {32'hE0000004, 32'hE0000001, 32'hE0000002, 32'hE0000003});
    wr(5'h0C, 32'hF0F0F0F0);
    wr(5'h00, 32'h0);
    wr(5'h0C, 32'h5A5A5A5A);
    check("R3 rewind on zero", keyOut, {32'h5A5A5A5A, 32'hF0F0F0F0, 32'hE0000002, 32'hE0000003});
  endtask

  task automatic t_start();
    logic [31:0] v;
    logic [127:0] keySnap;
    keySnap = keyOut;
    wr(5'h00, 32'hD0001005);
    check("R4 pulse high", startPulse, 1);
    check("R5 fields", {cipherEn, decrypt, useNewIv, blockCountM1}, {1'b1, 1'b0, 1'b1, 12'd5});
    @(negedge clk);
    check("R4 pulse single", startPulse, 0);
    rd(5'h00, v); check("R5 ctrl readback busy", v, 32'hD0001005);
    wr(5'h04, 32'hAAAA0000);
    wr(5'h00, 32'h08000001);
    wr(5'h0C, 32'h99999999);
    rd(5'h04, v); check("R8 src ignored", v, 32'h12345670);
    rd(5'h00, v); check("R8 ctrl ignored", v, 32'hD0001005);
    check("R8 key ignored", keyOut, keySnap);
    check("R4 busy held", busy, 1);
    done(1'b0);
    check("R4 busy cleared", busy, 0);
    check("R7 irq raised", irq, 1);
    repeat (3) @(negedge clk);
    check("R7 irq holds", irq, 1);
    rd(5'h00, v); check("R5 ctrl after done", v, 32'h50001005);
    wr(5'h00, 32'h08000003);
    check("R7 irq cleared", irq, 0);
    rd(5'h00, v); check("R5 decrypt latched", v, 32'h08000003);
    check("R5 decrypt port", decrypt, 1);
  endtask

  task automatic t_err();
    logic [31:0] v;
    wr(5'h00, 32'h80000000);
    done(1'b1);
    check("R7 no irq when disabled", irq, 0);
    rd(5'h00, v); check("R6 err set", v, 32'h20000000);
    wr(5'h00, 32'h08000000);
    rd(5'h00, v); check("R6 err sticky", v, 32'h28000000);
    wr(5'h00, 32'h0);
    rd(5'h00, v); check("R6 err cleared", v, 32'h0);
  endtask

  task automatic t_busyZero();
    logic [31:0] v;
    wr(5'h00, 32'h0);
    wr(5'h0C, 32'h77777777);
    wr(5'h00, 32'hC0000000);
    wr(5'h00, 32'h0);
    rd(5'h00, v); check("R8 zero keeps busy and fields", v, 32'hC0000000);
    done(1'b0);
    check("R7 irq after zero-while-busy", irq, 1);
    wr(5'h0C, 32'h66666666);
    check("R8 zero rewound pointer", keyOut[127:96], 32'h66666666);
  endtask

  task automatic t_idleDone();
    logic [31:0] v;
    wr(5'h00, 32'h40000000);
    check("R7 clear by write", irq, 0);
    done(1'b1);
    rd(5'h00, v); check("R10 idle done ignored", v, 32'h40000000);
    check("R10 idle irq", irq, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] v;
    wr(5'h00, 32'h07FFE000);
    rd(5'h00, v); check("R9 reserved bits", v, 32'h0);
    rd(5'h0C, v); check("R9 key port reads 0", v, 32'h0);
    rd(5'h10, v); check("R9 iv port reads 0", v, 32'h0);
    wr(5'h14, 32'hDEADBEEF);
    rd(5'h14, v); check("R9 unmapped reads 0", v, 32'h0);
    check("R9 unmapped write harmless", {busy, startPulse}, 2'b00);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_addr();
    t_key();
    t_wrap();
    t_start();
    t_err();
    t_busyZero();
    t_idleDone();
    t_unmapped();
    finishRun();
  end
endmodule